// File: doc/BRIEF.md
# Multicart outer bank controller

This block sits next to an inner bank-switching controller on a game multicart. It holds a four-bit outer register that the CPU writes anywhere in the `$6000`-`$7FFF` window. From that register it turns CPU program fetches and PPU pattern fetches into a final chip address and a chip enable for one of six memories:

- a 32 KiB menu program ROM;
- two 512 KiB game program ROMs;
- two 512 KiB game graphics ROMs;
- an 8 KiB graphics RAM.

The inner controller's banked address bits come in as inputs.

After reset the board is in menu mode. The CPU runs the menu ROM directly, and the PPU sees the graphics RAM without banking. When the menu writes the register with its mode bit set, the block moves to game mode. In game mode the chosen 128 KiB window of the program and graphics ROM spaces is exposed to the inner controller's banking. The register then locks, and only a reset clears it.

Top module: `mc_outer_bank`

## Requirements
- R1: After reset (asserted asynchronously, released two clock edges after `rst_n` rises), `game_mode` is 0 and the window is 0. The register returns to this state whenever `rst_n` goes low.
- R2: A write is taken when `cpu_wr` is high on a rising clock edge and `(cpu_addr & 16'hE000) == 16'h6000`, that is for any address from `$6000` to `$7FFF`. The new value drives the outputs after that edge.
- R3: In an accepted write, `cpu_data[4]` becomes the mode (1 means game) and `cpu_data[2:0]` becomes the window. Data bits 7..5 and 3 have no effect.
- R4: While `game_mode` is 1, writes to `$6000`-`$7FFF` change nothing, until the next reset.
- R5: Writes to any address outside `$6000`-`$7FFF` leave the register unchanged. This includes the inner controller's registers at `$8000`-`$FFFF` and its work-RAM control register.
- R6: In menu mode, a fetch with `cpu_addr[15]=1` raises `prg_menu_ce` and gives `prg_addr = {4'b0, cpu_addr[14:0]}`. `inner_prg` is ignored and `prg_game_ce` is 0.
- R7: In game mode, a fetch with `cpu_addr[15]=1` gives `prg_addr = {win[1:0], inner_prg, cpu_addr[12:0]}`. `prg_game_ce[win[2]]` is the only program enable raised.
- R8: In menu mode, a pattern fetch (`ppu_addr[13]=0`) raises `chr_ram_ce` with `chr_addr = {6'b0, ppu_addr[12:0]}`, and `chr_rom_ce` is 0.
- R9: In game mode, a pattern fetch gives `chr_addr = {win[1:0], inner_chr, ppu_addr[9:0]}` and raises only `chr_rom_ce[win[2]]`. `chr_ram_ce` stays 0.
- R10: With `cpu_addr[15]=0` no program enable is raised. With `ppu_addr[13]=1` no graphics enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| inner_prg | input | 4 | Inner controller program bank bits A16..A13 |
| ppu_addr | input | 14 | PPU address |
| inner_chr | input | 7 | Inner controller graphics bank bits A16..A10 |
| prg_addr | output | 19 | Address into the selected program chip |
| prg_menu_ce | output | 1 | Menu program ROM enable |
| prg_game_ce | output | 2 | Game program ROM enables, one per chip |
| chr_addr | output | 19 | Address into the selected graphics chip |
| chr_ram_ce | output | 1 | Graphics RAM enable |
| chr_rom_ce | output | 2 | Game graphics ROM enables, one per chip |
| game_mode | output | 1 | High once game mode is entered |

## Verification
The following are checked by assertions on every cycle:
- a qualifying write loads the mode and window fields;
- a non-qualifying cycle leaves the register untouched;
- a set lock keeps both mode and window frozen;
- at most one chip of each space is enabled;
- the graphics RAM never opens in game mode, and menu mode never opens a game ROM.

Only the bench's scenarios show the following:
- the exact address concatenations;
- which chip of a pair the top window bit picks;
- that the inner bank inputs are ignored in menu mode;
- that an asynchronous reset clears a locked register.

// File: rtl/mc_outer_pkg.sv
package mc_outer_pkg;
  localparam int WIN_W    = 3;
  localparam int MODE_BIT = 4;
  localparam int CPU_AW   = 16;
  localparam int DATA_W   = 8;
  localparam logic [CPU_AW-1:0] DEC_MASK  = 16'hE000;
  localparam logic [CPU_AW-1:0] DEC_MATCH = 16'h6000;

  typedef struct packed {
    logic             game;
    logic [WIN_W-1:0] win;
  } outer_t;
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mc_outer_reg.sv
module mc_outer_reg
  import mc_outer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  output outer_t            outer_q
);
  logic   dec_hit;
  logic   load_en;
  outer_t outer_d;

  always_comb begin
    dec_hit = (cpu_addr & DEC_MASK) == DEC_MATCH;
    load_en = cpu_wr && dec_hit && !outer_q.game;
    outer_d = outer_q;
    if (load_en) begin
      outer_d.game = cpu_data[MODE_BIT];
      outer_d.win  = cpu_data[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       outer_q <= '0;
    else if (load_en) outer_q <= outer_d;
  end

  logic unused_data;
  assign unused_data = ^{cpu_data[DATA_W-1:MODE_BIT+1], cpu_data[MODE_BIT-1:WIN_W]};
endmodule

// File: rtl/mc_prg_map.sv
module mc_prg_map
  import mc_outer_pkg::*;
#(
  parameter  int PRG_IN_W = 4,
  parameter  int PAGE_AW  = 13,
  parameter  int MENU_AW  = 15,
  localparam int CHIP_AW  = WIN_W - 1 + PRG_IN_W + PAGE_AW,
  localparam int N_CHIPS  = 2
) (
  input  outer_t              outer_q,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [PRG_IN_W-1:0] inner_prg,
  output logic [CHIP_AW-1:0]  prg_addr,
  output logic                prg_menu_ce,
  output logic [N_CHIPS-1:0]  prg_game_ce
);
  localparam int PAD_W = CHIP_AW - MENU_AW;

  logic rom_space;
  assign rom_space = cpu_addr[CPU_AW-1];

  always_comb begin
    if (outer_q.game)
      prg_addr = {outer_q.win[WIN_W-2:0], inner_prg, cpu_addr[PAGE_AW-1:0]};
    else
      prg_addr = {{PAD_W{1'b0}}, cpu_addr[MENU_AW-1:0]};
  end

  assign prg_menu_ce = rom_space && !outer_q.game;

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_chip
    assign prg_game_ce[i] = rom_space && outer_q.game && (outer_q.win[WIN_W-1] == 1'(i));
  end
endmodule

// File: rtl/mc_chr_map.sv
module mc_chr_map
  import mc_outer_pkg::*;
#(
  parameter  int CHR_IN_W = 7,
  parameter  int PAGE_AW  = 10,
  parameter  int RAM_AW   = 13,
  parameter  int PPU_AW   = 14,
  localparam int CHIP_AW  = WIN_W - 1 + CHR_IN_W + PAGE_AW,
  localparam int N_CHIPS  = 2
) (
  input  outer_t              outer_q,
  input  logic [PPU_AW-1:0]   ppu_addr,
  input  logic [CHR_IN_W-1:0] inner_chr,
  output logic [CHIP_AW-1:0]  chr_addr,
  output logic                chr_ram_ce,
  output logic [N_CHIPS-1:0]  chr_rom_ce
);
  localparam int PAD_W = CHIP_AW - RAM_AW;

  logic pattern;
  assign pattern = !ppu_addr[PPU_AW-1];

  always_comb begin
    if (outer_q.game)
      chr_addr = {outer_q.win[WIN_W-2:0], inner_chr, ppu_addr[PAGE_AW-1:0]};
    else
      chr_addr = {{PAD_W{1'b0}}, ppu_addr[RAM_AW-1:0]};
  end

  assign chr_ram_ce = pattern && !outer_q.game;

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_chip
    assign chr_rom_ce[i] = pattern && outer_q.game && (outer_q.win[WIN_W-1] == 1'(i));
  end
endmodule

// File: rtl/mc_outer_bank.sv
module mc_outer_bank
  import mc_outer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic [3:0]  inner_prg,
  input  logic [13:0] ppu_addr,
  input  logic [6:0]  inner_chr,
  output logic [18:0] prg_addr,
  output logic        prg_menu_ce,
  output logic [1:0]  prg_game_ce,
  output logic [18:0] chr_addr,
  output logic        chr_ram_ce,
  output logic [1:0]  chr_rom_ce,
  output logic        game_mode
);
  logic   rst_sync_n;
  outer_t outer_q;

  mc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mc_outer_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .outer_q  (outer_q)
  );

  mc_prg_map #(.PRG_IN_W(4), .PAGE_AW(13), .MENU_AW(15)) u_prg (
    .outer_q     (outer_q),
    .cpu_addr    (cpu_addr),
    .inner_prg   (inner_prg),
    .prg_addr    (prg_addr),
    .prg_menu_ce (prg_menu_ce),
    .prg_game_ce (prg_game_ce)
  );

  mc_chr_map #(.CHR_IN_W(7), .PAGE_AW(10), .RAM_AW(13), .PPU_AW(14)) u_chr (
    .outer_q    (outer_q),
    .ppu_addr   (ppu_addr),
    .inner_chr  (inner_chr),
    .chr_addr   (chr_addr),
    .chr_ram_ce (chr_ram_ce),
    .chr_rom_ce (chr_rom_ce)
  );

  assign game_mode = outer_q.game;
endmodule

// File: rtl/mc_outer_chk.sv
module mc_outer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        game_mode,
  input logic [2:0]  win,
  input logic        prg_menu_ce,
  input logic [1:0]  prg_game_ce,
  input logic        chr_ram_ce,
  input logic [1:0]  chr_rom_ce
);
  logic in_window;
  assign in_window = (cpu_addr[15:13] == 3'b011);

  a_r3_fields_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_window && !game_mode) |=>
      (game_mode == $past(cpu_data[4])) && (win == $past(cpu_data[2:0])));

  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    game_mode |=> game_mode && $stable(win));

  a_r5_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && in_window) |=> $stable(win) && $stable(game_mode));

  a_r7_one_prg_chip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prg_menu_ce, prg_game_ce}));

  a_r6_menu_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
    !game_mode |-> (prg_game_ce == 2'b00) && (chr_rom_ce == 2'b00));

  a_r9_game_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    game_mode |-> !chr_ram_ce && $onehot0(chr_rom_ce));

  a_r10_low_space_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> !prg_menu_ce && (prg_game_ce == 2'b00));
endmodule

bind mc_outer_bank mc_outer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_wr      (cpu_wr),
  .cpu_addr    (cpu_addr),
  .cpu_data    (cpu_data),
  .game_mode   (outer_q.game),
  .win         (outer_q.win),
  .prg_menu_ce (prg_menu_ce),
  .prg_game_ce (prg_game_ce),
  .chr_ram_ce  (chr_ram_ce),
  .chr_rom_ce  (chr_rom_ce)
);

// File: tb/sim_mc_outer_bank.sv
module sim_mc_outer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [3:0]  inner_prg = '0;
  logic [13:0] ppu_addr = '0;
  logic [6:0]  inner_chr = '0;
  logic [18:0] prg_addr;
  logic        prg_menu_ce;
  logic [1:0]  prg_game_ce;
  logic [18:0] chr_addr;
  logic        chr_ram_ce;
  logic [1:0]  chr_rom_ce;
  logic        game_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_outer_bank u0 (.*);

  typedef struct packed {
    logic        wr;
    logic [15:0] waddr;
    logic [7:0]  wdata;
    logic [15:0] faddr;
    logic [3:0]  iprg;
    logic [6:0]  ichr;
    logic [13:0] paddr;
    logic        game;
    logic [2:0]  win;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 4'h5, 7'h11, 14'h0456, 1'b0, 3'd0}, // R6 R8 menu after reset
    '{1'b1, 16'h6000, 8'h05, 16'hFFFF, 4'h5, 7'h11, 14'h1FFF, 1'b0, 3'd5}, // R2 R3 window load, R6
    '{1'b1, 16'h8000, 8'h17, 16'h9ABC, 4'hA, 7'h22, 14'h0ABC, 1'b0, 3'd5}, // R5 inner reg write
    '{1'b1, 16'h5FFF, 8'h13, 16'hC001, 4'h3, 7'h33, 14'h1000, 1'b0, 3'd5}, // R5 just below window
    '{1'b1, 16'h7FFF, 8'h03, 16'h8000, 4'h0, 7'h00, 14'h0000, 1'b0, 3'd3}, // R2 top of window
    '{1'b0, 16'h0000, 8'h00, 16'h6ABC, 4'h7, 7'h44, 14'h2400, 1'b0, 3'd3}, // R10 menu
    '{1'b1, 16'hA001, 8'h1F, 16'hE123, 4'h1, 7'h55, 14'h0321, 1'b0, 3'd3}, // R5 work-RAM ctrl reg
    '{1'b1, 16'h6ABC, 8'hF6, 16'hC000, 4'hF, 7'h7F, 14'h03FF, 1'b1, 3'd6}, // R3 R7 R9 chip 1
    '{1'b1, 16'h6000, 8'h01, 16'h8765, 4'h2, 7'h01, 14'h1555, 1'b1, 3'd6}, // R4 locked
    '{1'b1, 16'h7FFF, 8'h12, 16'hFFFF, 4'h9, 7'h3C, 14'h0C00, 1'b1, 3'd6}, // R4 locked
    '{1'b0, 16'h0000, 8'h00, 16'h7FFF, 4'h9, 7'h3C, 14'h2000, 1'b1, 3'd6}  // R10 game
  };

  function automatic logic [43:0] model(input logic g, input logic [2:0] w,
      input logic [15:0] fa, input logic [3:0] ip, input logic [6:0] ic,
      input logic [13:0] pa);
    logic [18:0] e_pa, e_ca;
    logic        e_menu, e_ram;
    logic [1:0]  e_pce, e_rce, chip;
    chip = w[2] ? 2'b10 : 2'b01;
    if (g) begin
      e_pa = {w[1:0], ip, fa[12:0]};
      e_menu = 1'b0;
      e_pce = fa[15] ? chip : 2'b00;
      e_ca = {w[1:0], ic, pa[9:0]};
      e_ram = 1'b0;
      e_rce = !pa[13] ? chip : 2'b00;
    end else begin
      e_pa = {4'b0, fa[14:0]};
      e_menu = fa[15];
      e_pce = 2'b00;
      e_ca = {6'b0, pa[12:0]};
      e_ram = !pa[13];
      e_rce = 2'b00;
    end
    return {e_pa, e_menu, e_pce, e_ca, e_ram, e_rce};
  endfunction

  task automatic check(input string tag, input logic g, input logic [2:0] w);
    logic [43:0] exp_v, act_v;
    exp_v = model(g, w, cpu_addr, inner_prg, inner_chr, ppu_addr);
    act_v = {prg_addr, prg_menu_ce, prg_game_ce, chr_addr, chr_ram_ce, chr_rom_ce};
    checks++;
    if (act_v !== exp_v || game_mode !== g) begin
      errors++;
      $display("FAIL %s: outputs=%h mode=%b expected outputs=%h mode=%b",
               tag, act_v, game_mode, exp_v, g);
    end
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] fa, input logic [3:0] ip,
                       input logic [6:0] ic, input logic [13:0] pa);
    cpu_addr = fa; inner_prg = ip; inner_chr = ic; ppu_addr = pa;
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expected completion, actual timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    release_reset();
    fetch(16'hA5A5, 4'hF, 7'h7F, 14'h1234);
    check("R1 reset state", 1'b0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) write_reg(TBL[i].waddr, TBL[i].wdata);
      else @(negedge clk);
      fetch(TBL[i].faddr, TBL[i].iprg, TBL[i].ichr, TBL[i].paddr);
      check($sformatf("table vector %0d", i), TBL[i].game, TBL[i].win);
    end

    // R1: asynchronous reset clears a locked register
    @(negedge clk);
    #2 rst_n = 1'b0;
    fetch(16'hC000, 4'h3, 7'h05, 14'h0100);
    check("R1 async clear of lock", 1'b0, 3'd0);
    release_reset();
    check("R1 state after release", 1'b0, 3'd0);

    // R3 R4 R7 R9: reset unlocks, game entry with window on chip 0
    write_reg(16'h7000, 8'h11);
    fetch(16'hBEEF, 4'h6, 7'h2A, 14'h0777);
    check("R3 R7 R9 game window 1", 1'b1, 3'd1);
    write_reg(16'h6000, 8'h04);
    fetch(16'h8001, 4'h8, 7'h40, 14'h1FFF);
    check("R4 write after lock ignored", 1'b1, 3'd1);

    // R10: neither space addressed in game mode
    fetch(16'h4000, 4'h8, 7'h40, 14'h3F00);
    check("R10 no enables", 1'b1, 3'd1);

    // R2: write strobe low in window does nothing (new reset first)
    rst_n = 1'b0;
    #3;
    release_reset();
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_data = 8'h17; cpu_wr = 1'b0;
    @(posedge clk);
    #1 fetch(16'h9000, 4'h1, 7'h01, 14'h0010);
    check("R2 no strobe no load", 1'b0, 3'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule